// File: doc/BRIEF.md
# Cycle-stealing DMA controller

A single-channel transfer engine that moves a block of words between one I/O device and memory while borrowing the shared bus from the CPU one word at a time. Software programs four things before starting: the direction, the device address, the first memory address and the number of words. After that the engine works through the block without further CPU help.

Each word is moved through the controller in two separate bus ownerships. In the first, the engine reads the word from the source. In the second, it writes the word to the destination. Between the two ownerships, and after the second, the bus request is dropped so the CPU can take the bus back. The CPU is only held off for the stolen cycles and takes no interrupt per word. One interrupt is raised when the whole block has been moved. It stays raised until software clears it.

The bus side has a request/grant pair and one access port. On that port, `bus_dev_o` selects device space rather than memory space. A read or write strobe is held until `bus_ack_i` arrives.

Top module: `cs_dma`

## Requirements
- R1: Configuration is written through `cfg_we_i`/`cfg_addr_i`/`cfg_wdata_i`, with these offsets:
  - 0 is control: bit 0 starts the block, bit 1 selects the direction (1 = memory to device, 0 = device to memory), bit 2 clears the done flag.
  - 1 is the device address.
  - 2 is the first memory address.
  - 3 is the word count.
- R2: A word transfer begins with a bus request only after `dev_rdy_i` is seen high. Read and write strobes appear only while both `bus_req_o` and `bus_gnt_i` are high.
- R3: Each word takes exactly two bus ownerships:
  - The first ownership is a read of the source and the second is a write of that data to the destination.
  - `bus_req_o` falls in the cycle after each acknowledged access.
  - The strobe and address hold steady until `bus_ack_i`.
- R4: Device accesses (`bus_dev_o` = 1) always carry the programmed device address. With direction 0 the device is read and memory written; with direction 1 memory is read and the device written.
- R5: Exactly the programmed count of words is moved. The memory address starts at the programmed value and rises by one per word.
- R6: `busy_o` rises in the cycle after a start write with a non-zero count. It falls in the same cycle that the interrupt rises after the last write acknowledge. The bus is quiet whenever `busy_o` is low.
- R7: `irq_o` rises after the last word and stays high until a control write with bit 2 set. If that clear meets the final acknowledge in the same cycle, the completion wins and `irq_o` stays high.
- R8: A start with a count of zero makes no bus request, leaves `busy_o` low and raises `irq_o` in the next cycle.
- R9: While `busy_o` is high, start, direction, address and count writes are ignored; only the done-clear bit is honoured.
- R10: After reset `busy_o`, `irq_o`, `bus_req_o`, `bus_rd_o` and `bus_wr_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_addr_i | input | 2 | Configuration register offset |
| cfg_wdata_i | input | DW | Configuration write data |
| dev_rdy_i | input | 1 | Device has a word ready / can accept one |
| bus_req_o | output | 1 | Bus request to the arbiter |
| bus_gnt_i | input | 1 | Bus grant from the arbiter |
| bus_addr_o | output | AW | Access address |
| bus_dev_o | output | 1 | 1 = device space, 0 = memory space |
| bus_rd_o | output | 1 | Read strobe |
| bus_wr_o | output | 1 | Write strobe |
| bus_wdata_o | output | DW | Write data |
| bus_rdata_i | input | DW | Read data, valid with acknowledge |
| bus_ack_i | input | 1 | Access acknowledge |
| busy_o | output | 1 | Block transfer in progress |
| irq_o | output | 1 | Completion interrupt |

## Verification
Two events can land in the same cycle: the engine completes a block, and software writes the done-clear bit. The bench's bus responder is armed to drive the clear write in exactly the cycle it acknowledges the final write of a one-word block. The outcome is judged by requiring `irq_o` to be high afterwards and to stay high until a later, separate clear. Random grant and acknowledge latencies and a toggling device-ready also let start-while-busy writes land in the middle of word transfers.

// File: rtl/cs_dma_pkg.sv
package cs_dma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT, ST_REQ_A, ST_ACC_A, ST_GAP, ST_REQ_B, ST_ACC_B
  } dma_state_e;

  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_DEV  = 2'd1;
  localparam logic [1:0] REG_MEM  = 2'd2;
  localparam logic [1:0] REG_CNT  = 2'd3;

  localparam int CTRL_GO  = 0;
  localparam int CTRL_DIR = 1;
  localparam int CTRL_CLR = 2;
endpackage

// File: rtl/cs_dma_regs.sv
module cs_dma_regs
  import cs_dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [1:0]    cfg_addr_i,
  input  logic [DW-1:0] cfg_wdata_i,
  input  logic          busy_i,
  input  logic          done_set_i,
  output logic          start_o,
  output logic          dir_o,
  output logic [AW-1:0] dev_addr_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [CW-1:0] count_o,
  output logic          irq_o
);
  logic open_wr, ctrl_wr, clr_wr;
  logic done_q;
  logic unused_wdata;

  assign open_wr = cfg_we_i && !busy_i;
  assign ctrl_wr = open_wr && (cfg_addr_i == REG_CTRL);
  assign start_o = ctrl_wr && cfg_wdata_i[CTRL_GO];
  // clear is honoured even while busy
  assign clr_wr  = cfg_we_i && (cfg_addr_i == REG_CTRL) && cfg_wdata_i[CTRL_CLR];
  assign unused_wdata = ^cfg_wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_o      <= 1'b0;
      dev_addr_o <= '0;
      mem_addr_o <= '0;
      count_o    <= '0;
    end else if (open_wr) begin
      unique case (cfg_addr_i)
        REG_CTRL: dir_o      <= cfg_wdata_i[CTRL_DIR];
        REG_DEV:  dev_addr_o <= cfg_wdata_i[AW-1:0];
        REG_MEM:  mem_addr_o <= cfg_wdata_i[AW-1:0];
        REG_CNT:  count_o    <= cfg_wdata_i[CW-1:0];
        default:  ;
      endcase
    end
  end

  // completion beats a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         done_q <= 1'b0;
    else if (done_set_i) done_q <= 1'b1;
    else if (clr_wr)     done_q <= 1'b0;
  end

  assign irq_o = done_q;
endmodule

// File: rtl/cs_dma_engine.sv
module cs_dma_engine
  import cs_dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          dir_i,
  input  logic [AW-1:0] dev_addr_i,
  input  logic [AW-1:0] mem_base_i,
  input  logic [CW-1:0] count_i,
  input  logic          dev_rdy_i,
  input  logic          gnt_i,
  input  logic          ack_i,
  input  logic [DW-1:0] rdata_i,
  output logic          busy_o,
  output logic          done_set_o,
  output logic          req_o,
  output logic          rd_o,
  output logic          wr_o,
  output logic          dev_sel_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o
);
  dma_state_e    state_q, state_d;
  logic [AW-1:0] mem_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] data_q;
  logic          phase_b, use_dev, last_word;

  assign phase_b   = (state_q == ST_REQ_B) || (state_q == ST_ACC_B);
  assign use_dev   = phase_b ? dir_i : !dir_i;
  assign last_word = (cnt_q == CW'(1));

  assign req_o     = (state_q == ST_REQ_A) || (state_q == ST_ACC_A) || phase_b;
  assign rd_o      = (state_q == ST_ACC_A);
  assign wr_o      = (state_q == ST_ACC_B);
  assign dev_sel_o = req_o && use_dev;
  assign addr_o    = use_dev ? dev_addr_i : mem_q;
  assign wdata_o   = data_q;
  assign busy_o    = (state_q != ST_IDLE);

  assign done_set_o = ((state_q == ST_IDLE) && start_i && (count_i == '0)) ||
                      ((state_q == ST_ACC_B) && ack_i && last_word);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i && (count_i != '0)) state_d = ST_WAIT;
      ST_WAIT:  if (dev_rdy_i) state_d = ST_REQ_A;
      ST_REQ_A: if (gnt_i) state_d = ST_ACC_A;
      ST_ACC_A: if (ack_i) state_d = ST_GAP;
      ST_GAP:   state_d = ST_REQ_B;  // bus handed back for one cycle
      ST_REQ_B: if (gnt_i) state_d = ST_ACC_B;
      ST_ACC_B: if (ack_i) state_d = last_word ? ST_IDLE : ST_WAIT;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mem_q   <= '0;
      cnt_q   <= '0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      if ((state_q == ST_IDLE) && start_i) begin
        mem_q <= mem_base_i;
        cnt_q <= count_i;
      end
      if ((state_q == ST_ACC_A) && ack_i) data_q <= rdata_i;
      if ((state_q == ST_ACC_B) && ack_i) begin
        mem_q <= mem_q + AW'(1);
        cnt_q <= cnt_q - CW'(1);
      end
    end
  end
endmodule

// File: rtl/cs_dma.sv
module cs_dma
  import cs_dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [1:0]    cfg_addr_i,
  input  logic [DW-1:0] cfg_wdata_i,
  input  logic          dev_rdy_i,
  output logic          bus_req_o,
  input  logic          bus_gnt_i,
  output logic [AW-1:0] bus_addr_o,
  output logic          bus_dev_o,
  output logic          bus_rd_o,
  output logic          bus_wr_o,
  output logic [DW-1:0] bus_wdata_o,
  input  logic [DW-1:0] bus_rdata_i,
  input  logic          bus_ack_i,
  output logic          busy_o,
  output logic          irq_o
);
  logic          start, dir, done_set;
  logic [AW-1:0] dev_addr, mem_base;
  logic [CW-1:0] count;

  cs_dma_regs #(.AW(AW), .CW(CW), .DW(DW)) regs_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_we_i   (cfg_we_i),
    .cfg_addr_i (cfg_addr_i),
    .cfg_wdata_i(cfg_wdata_i),
    .busy_i     (busy_o),
    .done_set_i (done_set),
    .start_o    (start),
    .dir_o      (dir),
    .dev_addr_o (dev_addr),
    .mem_addr_o (mem_base),
    .count_o    (count),
    .irq_o      (irq_o)
  );

  cs_dma_engine #(.AW(AW), .CW(CW), .DW(DW)) engine_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .dir_i      (dir),
    .dev_addr_i (dev_addr),
    .mem_base_i (mem_base),
    .count_i    (count),
    .dev_rdy_i  (dev_rdy_i),
    .gnt_i      (bus_gnt_i),
    .ack_i      (bus_ack_i),
    .rdata_i    (bus_rdata_i),
    .busy_o     (busy_o),
    .done_set_o (done_set),
    .req_o      (bus_req_o),
    .rd_o       (bus_rd_o),
    .wr_o       (bus_wr_o),
    .dev_sel_o  (bus_dev_o),
    .addr_o     (bus_addr_o),
    .wdata_o    (bus_wdata_o)
  );
endmodule

// File: rtl/cs_dma_chk.sv
module cs_dma_chk
  import cs_dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cfg_we_i,
  input logic [1:0]    cfg_addr_i,
  input logic [DW-1:0] cfg_wdata_i,
  input logic          bus_req_o,
  input logic          bus_gnt_i,
  input logic [AW-1:0] bus_addr_o,
  input logic          bus_rd_o,
  input logic          bus_wr_o,
  input logic          bus_ack_i,
  input logic          busy_o,
  input logic          irq_o
);
  logic clr_wr;
  assign clr_wr = cfg_we_i && (cfg_addr_i == REG_CTRL) && cfg_wdata_i[CTRL_CLR];

  assert_strobe_granted_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_o || bus_wr_o) |-> (bus_req_o && bus_gnt_i));

  assert_single_strobe_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_rd_o && bus_wr_o));

  assert_release_after_ack_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((bus_rd_o || bus_wr_o) && bus_ack_i) |=> !bus_req_o);

  assert_read_held_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_o && !bus_ack_i) |=> (bus_rd_o && $stable(bus_addr_o)));

  assert_write_held_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_o && !bus_ack_i) |=> (bus_wr_o && $stable(bus_addr_o)));

  assert_idle_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !(bus_req_o || bus_rd_o || bus_wr_o));

  assert_irq_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !clr_wr) |=> irq_o);
endmodule

bind cs_dma cs_dma_chk #(.AW(AW), .DW(DW)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_we_i   (cfg_we_i),
  .cfg_addr_i (cfg_addr_i),
  .cfg_wdata_i(cfg_wdata_i),
  .bus_req_o  (bus_req_o),
  .bus_gnt_i  (bus_gnt_i),
  .bus_addr_o (bus_addr_o),
  .bus_rd_o   (bus_rd_o),
  .bus_wr_o   (bus_wr_o),
  .bus_ack_i  (bus_ack_i),
  .busy_o     (busy_o),
  .irq_o      (irq_o)
);

// File: tb/cs_dma_tb_top.sv
module cs_dma_tb_top;
  localparam int AW = 16;
  localparam int CW = 16;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          cpu_we = 1'b0;
  logic [1:0]    cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic          clr_we = 1'b0;
  logic          cfg_we;
  logic [1:0]    cfg_addr;
  logic [DW-1:0] cfg_wdata;
  assign cfg_we    = cpu_we | clr_we;
  assign cfg_addr  = clr_we ? 2'd0 : cpu_addr;
  assign cfg_wdata = clr_we ? DW'(4) : cpu_wdata;

  logic rdy_en = 1'b0, rdy_rand_mode = 1'b0, rdy_rnd = 1'b0;
  logic dev_rdy;
  assign dev_rdy = rdy_en & (!rdy_rand_mode | rdy_rnd);

  logic          gnt = 1'b0, ack = 1'b0;
  logic [DW-1:0] rdata = '0;
  logic          req, dev_sel, rd, wr, busy, irq;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;

  cs_dma #(.AW(AW), .CW(CW), .DW(DW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .dev_rdy_i(dev_rdy),
    .bus_req_o(req), .bus_gnt_i(gnt),
    .bus_addr_o(addr), .bus_dev_o(dev_sel),
    .bus_rd_o(rd), .bus_wr_o(wr),
    .bus_wdata_o(wdata), .bus_rdata_i(rdata), .bus_ack_i(ack),
    .busy_o(busy), .irq_o(irq)
  );

  function automatic logic [DW-1:0] mem_init(input int i);
    return DW'(i) * 32'h9E37_79B1 + 32'd7;
  endfunction
  function automatic logic [DW-1:0] dev_val(input int k);
    return 32'hA500_0000 ^ (DW'(k) * 32'h0101_0101);
  endfunction

  // shared expectations, written by main only
  logic          exp_dir = 1'b0;
  logic [AW-1:0] exp_dev = '0;
  logic          clr_arm = 1'b0;

  // bus responder model
  logic [DW-1:0] mem [256];
  logic [DW-1:0] dev_log [512];
  int dev_rd_cnt = 0, dev_wr_cnt = 0;
  int r_checks = 0, r_fails = 0;
  logic last_rd = 1'b0, clr_fired = 1'b0;

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] = mem_init(i);
      ack = 1'b0;
    end else begin
      rdy_rnd = ($urandom % 4) != 0;
      if (clr_we) clr_we = 1'b0;
      if (ack) ack = 1'b0;
      else if (rd || wr) begin
        r_checks++;
        if (!gnt) begin r_fails++; $display("FAIL R2 strobe without grant act=%0d exp=1", gnt); end
        if (($urandom % 3) != 0) begin
          ack = 1'b1;
          if (dev_sel) begin
            r_checks++;
            if (addr != exp_dev) begin
              r_fails++; $display("FAIL R4 device address act=%0h exp=%0h", addr, exp_dev);
            end
          end
          r_checks++;
          if (rd) begin
            if (last_rd || dev_sel != !exp_dir) begin
              r_fails++; $display("FAIL R3/R4 read order/space act=%0d exp=%0d", dev_sel, !exp_dir);
            end
            rdata = dev_sel ? dev_val(dev_rd_cnt) : mem[addr[7:0]];
            if (dev_sel) dev_rd_cnt++;
            last_rd = 1'b1;
          end else begin
            if (!last_rd || dev_sel != exp_dir) begin
              r_fails++; $display("FAIL R3/R4 write order/space act=%0d exp=%0d", dev_sel, exp_dir);
            end
            if (dev_sel) begin dev_log[dev_wr_cnt % 512] = wdata; dev_wr_cnt++; end
            else mem[addr[7:0]] = wdata;
            last_rd = 1'b0;
            if (clr_arm && !clr_fired) begin clr_we = 1'b1; clr_fired = 1'b1; end
          end
        end
      end
      if (!clr_arm) clr_fired = 1'b0;
    end
  end

  // arbiter model and request-edge counter
  int   req_rises = 0;
  logic req_prev = 1'b0;
  always @(negedge clk) begin
    if (!req) gnt = 1'b0;
    else if (!gnt && ($urandom % 2) != 0) gnt = 1'b1;
    if (rst_n && req && !req_prev) req_rises++;
    req_prev = req;
  end

  int checks = 0, fails = 0;

  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic wait_done();
    logic prev_busy;
    int   n;
    prev_busy = busy;
    n = 0;
    while (!irq && n < 5000) begin
      prev_busy = busy;
      @(negedge clk);
      n++;
    end
    check(irq == 1'b1, "R7 irq after block", irq, 1);
    check(prev_busy && !busy, "R6 busy falls with irq", {prev_busy, busy}, 2'b10);
  endtask

  task automatic run_block(input logic d, input logic [AW-1:0] dv, input int base,
                           input int n, input bit hold_rdy);
    int rd0, wr0, rr0;
    exp_dir = d; exp_dev = dv;
    cfg_write(2'd0, DW'(4));
    cfg_write(2'd1, DW'(dv));
    cfg_write(2'd2, DW'(base));
    cfg_write(2'd3, DW'(n));
    rd0 = dev_rd_cnt; wr0 = dev_wr_cnt; rr0 = req_rises;
    if (hold_rdy) rdy_en = 1'b0;
    cfg_write(2'd0, DW'({d, 1'b1}));
    check(busy == 1'b1, "R6 busy after start", busy, 1);
    if (hold_rdy) begin
      repeat (20) @(negedge clk);
      check(req_rises == rr0 && !req, "R2 no request without device ready", req_rises - rr0, 0);
      rdy_en = 1'b1;
    end
    wait_done();
    check(req_rises - rr0 == 2 * n, "R3 two bus ownerships per word", req_rises - rr0, 2 * n);
    if (!d) begin
      check(dev_rd_cnt - rd0 == n, "R5 words read from device", dev_rd_cnt - rd0, n);
      for (int i = 0; i < n; i++)
        check(mem[(base + i) % 256] == dev_val(rd0 + i), "R5 memory word",
              mem[(base + i) % 256], dev_val(rd0 + i));
    end else begin
      check(dev_wr_cnt - wr0 == n, "R5 words written to device", dev_wr_cnt - wr0, n);
      for (int i = 0; i < n; i++)
        check(dev_log[(wr0 + i) % 512] == mem[(base + i) % 256], "R4 device word",
              dev_log[(wr0 + i) % 512], mem[(base + i) % 256]);
    end
  endtask

  task automatic summary(input int extra);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***",
             checks + r_checks + extra, fails + r_fails + extra);
  endtask

  initial begin
    int rr0, rd0;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check(!busy && !irq && !req && !rd && !wr, "R10 reset outputs", {busy, irq, req, rd, wr}, 0);
    rst_n = 1'b1;
    rdy_en = 1'b1;
    @(negedge clk);

    // R1 R4 R5 directed, both directions
    run_block(1'b0, 16'h0A5A, 10, 5, 1'b0);
    run_block(1'b1, 16'h1234, 40, 3, 1'b0);

    // R2 device-ready gating
    run_block(1'b0, 16'h0777, 60, 2, 1'b1);

    // R8 zero count
    cfg_write(2'd0, DW'(4));
    check(!irq, "R7 clear drops irq", irq, 0);
    cfg_write(2'd3, DW'(0));
    rr0 = req_rises;
    cfg_write(2'd0, DW'(1));
    check(irq && !busy, "R8 zero count completes at once", {irq, busy}, 2'b10);
    repeat (5) @(negedge clk);
    check(req_rises == rr0, "R8 no bus request", req_rises - rr0, 0);

    // R9 start and reconfigure while busy
    exp_dir = 1'b0; exp_dev = 16'h0055;
    cfg_write(2'd0, DW'(4));
    cfg_write(2'd1, DW'(16'h0055));
    cfg_write(2'd2, DW'(100));
    cfg_write(2'd3, DW'(4));
    rd0 = dev_rd_cnt;
    cfg_write(2'd0, DW'(1));
    cfg_write(2'd2, DW'(200));
    cfg_write(2'd3, DW'(1));
    cfg_write(2'd0, DW'(3));
    wait_done();
    check(dev_rd_cnt - rd0 == 4, "R9 count unchanged by busy write", dev_rd_cnt - rd0, 4);
    check(mem[200] == mem_init(200), "R9 memory address unchanged", mem[200], mem_init(200));
    for (int i = 0; i < 4; i++)
      check(mem[100 + i] == dev_val(rd0 + i), "R9 original block moved",
            mem[100 + i], dev_val(rd0 + i));

    // R7 completion versus same-cycle clear
    clr_arm = 1'b1;
    run_block(1'b0, 16'h0C0C, 120, 1, 1'b0);
    repeat (5) @(negedge clk);
    check(irq == 1'b1, "R7 completion wins over clear", irq, 1);
    clr_arm = 1'b0;
    cfg_write(2'd0, DW'(4));
    check(irq == 1'b0, "R7 later clear drops irq", irq, 0);

    // random blocks
    rdy_rand_mode = 1'b1;
    for (int b = 0; b < 10; b++)
      run_block(1'($urandom % 2), AW'($urandom), $urandom % 150, 1 + $urandom % 8, 1'b0);

    summary(0);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired act=150000 exp=0");
    summary(1);
    $finish;
  end
endmodule